// File: doc/BRIEF.md
# Command and Configuration Register Bank

This block is the slow-control register file of a detector readout FPGA. A host reaches it over a simple byte-wide register bus made of an address, a write strobe, a read strobe and 8-bit data. The bank keeps the configuration a sensor control engine needs: the sensor identity, the remote register address and write data, the broadcast opcode, the trigger delay, the internal trigger gap and the working mode. It presents each of these as a wide output field.

One address is not storage. A byte written there is decoded as a command, and each recognised command code drives a one-clock pulse on an output of its own. The commands are a whole-bank soft reset, an opcode broadcast, a remote register write and a remote register read. When the sensor control engine finishes a remote read, it offers the returned 16-bit value on a plain strobe input. The bank latches that value and counts the completed reads. Sixteen-bit fields occupy two neighbouring byte addresses, with the high byte at the lower address. The trigger gap can never hold zero.

Top module: `cfg_cmd_regbank`

## Requirements
- R1: After `rst_n` is released, every stored byte reads 0x00 except the trigger gap low byte, which reads 0x14. The gap output therefore shows 0x0014, the read count reads 0x00, the read data reads 0x0000 and `host_rdata` is 0x00.
- R2: Configuration bytes live at 0x10000000 + offset. The offsets are: 0x01 chip ID, 0x02/0x03 remote address high/low, 0x04/0x05 write data high/low, 0x06 broadcast opcode, 0x07/0x08 trigger delay high/low, 0x09/0x0A spare bytes, 0x0B/0x0C trigger gap high/low. Each of these reads back the last byte written. The matching 16-bit outputs are {high, low}.
- R3: A host write to address 0x00000000 with code 0xFF, 0x50, 0x9C or 0x4E raises `sysrst_pulse`, `bcast_pulse`, `rwrite_pulse` or `rread_pulse` respectively. The pulse rises in the cycle after the write and lasts exactly one clock. At most one pulse is high at any time.
- R4: Any other code written to 0x00000000 raises no pulse. The command address is not stored and always reads 0x00.
- R5: Code 0xFF also returns every register to its R1 value at the same clock edge, including the read count and the read data. This takes priority over a read-back strobe in the same cycle.
- R6: After any byte write to offset 0x0B or 0x0C, the combined gap value {0x0B, 0x0C} is stored as 0x0001 if it would otherwise be 0x0000. The gap output is never zero.
- R7: When `rb_valid` is high, `rb_data` is latched into the read data, readable as high byte at offset 0x0E and low byte at 0x0F. The 8-bit read count at offset 0x0D increments and wraps from 0xFF to 0x00.
- R8: Host writes to offsets 0x0D, 0x0E and 0x0F are ignored. Reads of any unmapped address return 0x00. Unmapped addresses include offset 0x00, offsets 0x11–0x1F and addresses outside the bank.
- R9: `host_rdata` takes the addressed value in the cycle after `host_rd` is sampled high. It holds that value until the next read.
- R10: Offset 0x10 is the mode byte. Bit 1 drives `int_trig_sel` and bit 0 drives `frame_sample_en`. Bits 7:2 are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 32 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| rb_valid | input | 1 | Completed remote read strobe |
| rb_data | input | 16 | Value returned by the remote read |
| chip_id | output | 8 | Sensor identity |
| remote_addr | output | 16 | Remote register address |
| remote_wdata | output | 16 | Remote register write data |
| bcast_opcode | output | 8 | Opcode to broadcast |
| trig_delay | output | 16 | Trigger delay in clock cycles |
| trig_gap | output | 16 | Internal trigger gap, never zero |
| int_trig_sel | output | 1 | 1 selects internal trigger, 0 external |
| frame_sample_en | output | 1 | 1 enables continuous frame sampling |
| sysrst_pulse | output | 1 | Soft reset command pulse |
| bcast_pulse | output | 1 | Broadcast command pulse |
| rwrite_pulse | output | 1 | Remote write command pulse |
| rread_pulse | output | 1 | Remote read command pulse |

## Verification
Three situations are hardest to reach from the ports.

- A zero gap. The host can only write one byte at a time, so a zero must be produced through a write sequence. The stimulus writes each high byte from a small set, followed by every possible low byte, and checks the gap after each write against a byte-at-a-time model.
- A wrap of the read count. This needs 256 completed reads, so the stimulus drives a long run of read-back strobes and checks the count by host reads.
- A read-back strobe in the same cycle as a soft reset. The bench forces this by starting a strobe in the same cycle as the 0xFF write.

Every one of the 256 command codes is swept to show that only the four recognised codes make pulses.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int HOST_AW = 32;
  localparam int HOST_DW = 8;
  localparam int OFS_W   = 5;
  localparam logic [HOST_AW-1:0] CMD_ADDR = 32'h0000_0000;
  localparam logic [HOST_AW-1:0] CFG_BASE = 32'h1000_0000;

  // Offsets that the read mux and the gap clamp depend on
  localparam int NUM_RW_BYTES = 12;     // offsets 0x01..0x0C
  localparam int OFS_GAP_HI   = 'h0B;
  localparam int OFS_RCOUNT   = 'h0D;
  localparam int OFS_RDATA_HI = 'h0E;
  localparam int OFS_RDATA_LO = 'h0F;
  localparam int OFS_MODE     = 'h10;
  localparam logic [15:0] GAP_RESET = 16'h0014;

  // Command codes, index = pulse bit
  localparam int NUM_CMDS = 4;
  localparam int CMD_SYSRST = 0;
  localparam int CMD_BCAST  = 1;
  localparam int CMD_RWRITE = 2;
  localparam int CMD_RREAD  = 3;
  localparam logic [7:0] CMD_CODES [NUM_CMDS] = '{8'hFF, 8'h50, 8'h9C, 8'h4E};
endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_we,
  input  logic [HOST_DW-1:0]  cmd_code,
  output logic [NUM_CMDS-1:0] hit,
  output logic [NUM_CMDS-1:0] pulse_q
);
  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_code
    assign hit[i] = cmd_we && (cmd_code == CMD_CODES[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= hit;
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import regbank_pkg::*;
#(
  parameter int NBYTES  = NUM_RW_BYTES,
  parameter int GAP_HI  = OFS_GAP_HI,
  parameter int MODE_AT = OFS_MODE,
  parameter logic [15:0] GAP_RV = GAP_RESET
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                we,
  input  logic [OFS_W-1:0]    ofs,
  input  logic [HOST_DW-1:0]  wdata,
  output logic [NBYTES*8-1:0] bytes_q,
  output logic [1:0]          mode_q
);
  localparam int GAP_LO = GAP_HI + 1;

  logic        gap_hit;
  logic [15:0] gap_cur, gap_mrg, gap_fix;

  assign gap_hit = we && (ofs == OFS_W'(GAP_HI) || ofs == OFS_W'(GAP_LO));
  assign gap_cur = {bytes_q[(GAP_HI-1)*8 +: 8], bytes_q[(GAP_LO-1)*8 +: 8]};

  always_comb begin
    gap_mrg = (ofs == OFS_W'(GAP_HI)) ? {wdata, gap_cur[7:0]} : {gap_cur[15:8], wdata};
    gap_fix = (gap_mrg == 16'h0000) ? 16'h0001 : gap_mrg;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int  OFS   = i + 1;
    localparam bit  IS_HI = (OFS == GAP_HI);
    localparam bit  IS_LO = (OFS == GAP_LO);
    localparam logic [7:0] RV = IS_HI ? GAP_RV[15:8] : (IS_LO ? GAP_RV[7:0] : 8'h00);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= RV;
      else if (clr)              q <= RV;
      else if (IS_HI && gap_hit) q <= gap_fix[15:8];
      else if (IS_LO && gap_hit) q <= gap_fix[7:0];
      else if (we && ofs == OFS_W'(OFS)) q <= wdata;
    end
    assign bytes_q[i*8 +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            mode_q <= '0;
    else if (clr)                          mode_q <= '0;
    else if (we && ofs == OFS_W'(MODE_AT)) mode_q <= wdata[1:0];
  end
endmodule

// File: rtl/readback_capture.sv
module readback_capture #(
  parameter int CNT_W = 8,
  parameter int RD_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rb_valid,
  input  logic [RD_W-1:0]  rb_data,
  output logic [CNT_W-1:0] count_q,
  output logic [RD_W-1:0]  data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      data_q  <= '0;
    end else if (clr) begin
      count_q <= '0;
      data_q  <= '0;
    end else if (rb_valid) begin
      count_q <= count_q + 1'b1;
      data_q  <= rb_data;
    end
  end
endmodule

// File: rtl/cfg_cmd_regbank.sv
module cfg_cmd_regbank
  import regbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               rb_valid,
  input  logic [15:0]        rb_data,
  output logic [7:0]         chip_id,
  output logic [15:0]        remote_addr,
  output logic [15:0]        remote_wdata,
  output logic [7:0]         bcast_opcode,
  output logic [15:0]        trig_delay,
  output logic [15:0]        trig_gap,
  output logic               int_trig_sel,
  output logic               frame_sample_en,
  output logic               sysrst_pulse,
  output logic               bcast_pulse,
  output logic               rwrite_pulse,
  output logic               rread_pulse
);
  localparam int NB = NUM_RW_BYTES;

  logic                is_cmd, is_cfg, soft_clr;
  logic [OFS_W-1:0]    ofs;
  logic [NUM_CMDS-1:0] cmd_hit, cmd_pulse;
  logic [NB*8-1:0]     cfg_bytes;
  logic [1:0]          mode_bits;
  logic [7:0]          rd_count;
  logic [15:0]         rd_value;
  logic [HOST_DW-1:0]  rd_mux;

  assign is_cmd   = (host_addr == CMD_ADDR);
  assign is_cfg   = (host_addr[HOST_AW-1:OFS_W] == CFG_BASE[HOST_AW-1:OFS_W]);
  assign ofs      = host_addr[OFS_W-1:0];
  assign soft_clr = cmd_hit[CMD_SYSRST];

  cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_we(host_wr && is_cmd), .cmd_code(host_wdata),
    .hit(cmd_hit), .pulse_q(cmd_pulse)
  );

  cfg_store #(.NBYTES(NB)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .we(host_wr && is_cfg), .ofs(ofs),
    .wdata(host_wdata), .bytes_q(cfg_bytes), .mode_q(mode_bits)
  );

  readback_capture #(.CNT_W(8), .RD_W(16)) u_rb (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .rb_valid(rb_valid), .rb_data(rb_data),
    .count_q(rd_count), .data_q(rd_value)
  );

  // Byte i of cfg_bytes holds offset i+1; 16-bit fields are big-endian
  assign chip_id         = cfg_bytes[0*8 +: 8];
  assign remote_addr     = {cfg_bytes[1*8 +: 8], cfg_bytes[2*8 +: 8]};
  assign remote_wdata    = {cfg_bytes[3*8 +: 8], cfg_bytes[4*8 +: 8]};
  assign bcast_opcode    = cfg_bytes[5*8 +: 8];
  assign trig_delay      = {cfg_bytes[6*8 +: 8], cfg_bytes[7*8 +: 8]};
  assign trig_gap        = {cfg_bytes[(OFS_GAP_HI-1)*8 +: 8], cfg_bytes[OFS_GAP_HI*8 +: 8]};
  assign int_trig_sel    = mode_bits[1];
  assign frame_sample_en = mode_bits[0];

  assign sysrst_pulse = cmd_pulse[CMD_SYSRST];
  assign bcast_pulse  = cmd_pulse[CMD_BCAST];
  assign rwrite_pulse = cmd_pulse[CMD_RWRITE];
  assign rread_pulse  = cmd_pulse[CMD_RREAD];

  always_comb begin
    rd_mux = '0;
    if (is_cfg) begin
      if (ofs >= OFS_W'(1) && ofs <= OFS_W'(NB))
        rd_mux = cfg_bytes[(int'(ofs) - 1)*8 +: 8];
      else if (ofs == OFS_W'(OFS_RCOUNT))   rd_mux = rd_count;
      else if (ofs == OFS_W'(OFS_RDATA_HI)) rd_mux = rd_value[15:8];
      else if (ofs == OFS_W'(OFS_RDATA_LO)) rd_mux = rd_value[7:0];
      else if (ofs == OFS_W'(OFS_MODE))     rd_mux = {6'b0, mode_bits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] host_addr,
  input logic        host_wr,
  input logic        host_rd,
  input logic [7:0]  host_wdata,
  input logic [7:0]  host_rdata,
  input logic        rb_valid,
  input logic [7:0]  chip_id,
  input logic [15:0] trig_gap,
  input logic [7:0]  rd_count,
  input logic        sysrst_pulse,
  input logic        bcast_pulse,
  input logic        rwrite_pulse,
  input logic        rread_pulse
);
  logic cmd_wr, known;
  assign cmd_wr = host_wr && (host_addr == 32'h0);
  assign known  = (host_wdata == 8'hFF) || (host_wdata == 8'h50) ||
                  (host_wdata == 8'h9C) || (host_wdata == 8'h4E);

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sysrst_pulse, bcast_pulse, rwrite_pulse, rread_pulse})); // R3
  AST_BCAST_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && host_wdata == 8'h50 |=> bcast_pulse); // R3
  AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !known |=> !(sysrst_pulse || bcast_pulse || rwrite_pulse || rread_pulse)); // R4
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && host_wdata == 8'hFF |=> sysrst_pulse && chip_id == 8'h00 &&
                                      trig_gap == 16'h0014 && rd_count == 8'h00); // R5
  AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig_gap != 16'h0000); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && !(cmd_wr && host_wdata == 8'hFF) |=> rd_count == $past(rd_count) + 8'd1); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata)); // R9
endmodule

bind cfg_cmd_regbank regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .rb_valid(rb_valid), .chip_id(chip_id),
  .trig_gap(trig_gap), .rd_count(rd_count), .sysrst_pulse(sysrst_pulse),
  .bcast_pulse(bcast_pulse), .rwrite_pulse(rwrite_pulse), .rread_pulse(rread_pulse)
);

// File: tb/tb_cfg_cmd_regbank.sv
module tb_cfg_cmd_regbank;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic clk = 0, rst_n = 0;
  logic [31:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0, rb_valid = 0;
  logic [7:0] host_wdata = '0, host_rdata, chip_id, bcast_opcode;
  logic [15:0] rb_data = '0, remote_addr, remote_wdata, trig_delay, trig_gap;
  logic int_trig_sel, frame_sample_en, sysrst_pulse, bcast_pulse, rwrite_pulse, rread_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_cmd_regbank dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  function automatic logic [31:0] pulses();
    return {28'h0, sysrst_pulse, bcast_pulse, rwrite_pulse, rread_pulse};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] gm;
    logic [7:0] vals [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);

    // R1 reset values
    chk("R1 rdata", {24'h0, host_rdata}, 32'h0);
    chk("R1 gap", {16'h0, trig_gap}, 32'h0014);
    for (int o = 1; o <= 16; o++) begin
      rd(BASE + o, d);
      chk("R1 byte", {24'h0, d}, (o == 'h0C) ? 32'h14 : 32'h0);
    end

    // R2 read/write sweep of stored bytes (gap bytes done under R6)
    for (int o = 1; o <= 10; o++)
      foreach (vals[k]) begin
        logic [7:0] v = vals[k] ^ 8'(o * 37);
        wr(BASE + o, v);
        rd(BASE + o, d);
        chk("R2 readback", {24'h0, d}, {24'h0, v});
      end
    wr(BASE + 1, 8'h77); wr(BASE + 2, 8'h12); wr(BASE + 3, 8'h34);
    wr(BASE + 4, 8'hBE); wr(BASE + 5, 8'hEF); wr(BASE + 6, 8'h5C);
    wr(BASE + 7, 8'hFF); wr(BASE + 8, 8'hFE);
    chk("R2 chip_id", {24'h0, chip_id}, 32'h77);
    chk("R2 remote_addr", {16'h0, remote_addr}, 32'h1234);
    chk("R2 remote_wdata", {16'h0, remote_wdata}, 32'hBEEF);
    chk("R2 bcast_opcode", {24'h0, bcast_opcode}, 32'h5C);
    chk("R2 trig_delay", {16'h0, trig_delay}, 32'hFFFE);

    // R10 mode byte sweep
    for (int v = 0; v < 256; v++) begin
      wr(BASE + 'h10, 8'(v));
      chk("R10 int_trig_sel", {31'h0, int_trig_sel}, (v >> 1) & 1);
      chk("R10 frame_sample_en", {31'h0, frame_sample_en}, v & 1);
      if (v % 51 == 0) begin
        rd(BASE + 'h10, d);
        chk("R10 readback", {24'h0, d}, v & 3);
      end
    end

    // R3 R4 R5 full command code sweep
    for (int c = 0; c < 256; c++) begin
      logic [31:0] exp;
      if (c == 'hFF) wr(BASE + 1, 8'h99);
      exp = {28'h0, c == 'hFF, c == 'h50, c == 'h9C, c == 'h4E};
      wr(32'h0, 8'(c));
      if (exp != 0) chk("R3 pulse", pulses(), exp);
      else          chk("R4 no pulse", pulses(), 0);
      @(negedge clk);
      chk("R3 one cycle", pulses(), 0);
      if (c == 'hFF) begin
        chk("R5 chip_id cleared", {24'h0, chip_id}, 0);
        chk("R5 gap reset", {16'h0, trig_gap}, 32'h0014);
        chk("R5 mode cleared", {30'h0, int_trig_sel, frame_sample_en}, 0);
      end
    end
    rd(32'h0, d);
    chk("R4 cmd reads zero", {24'h0, d}, 0);

    // R6 gap clamp sweep
    gm = 16'h0014;
    foreach (vals[k]) begin
      for (int lo = 0; lo < 256; lo++) begin
        wr(BASE + 'h0B, vals[k] & 8'h81);
        gm = {vals[k] & 8'h81, gm[7:0]}; if (gm == 0) gm = 1;
        chk("R6 gap after hi", {16'h0, trig_gap}, {16'h0, gm});
        wr(BASE + 'h0C, 8'(lo));
        gm = {gm[15:8], 8'(lo)}; if (gm == 0) gm = 1;
        chk("R6 gap after lo", {16'h0, trig_gap}, {16'h0, gm});
      end
    end
    rd(BASE + 'h0C, d);
    chk("R6 gap lo readback", {24'h0, d}, {24'h0, gm[7:0]});

    // R7 read-back capture and count wrap
    for (int n = 1; n <= 300; n++) begin
      rb_valid = 1; rb_data = 16'(n * 613);
      @(negedge clk); rb_valid = 0;
      if (n % 50 == 0 || n == 255 || n == 256) begin
        rd(BASE + 'h0D, d);
        chk("R7 count", {24'h0, d}, n % 256);
        rd(BASE + 'h0E, d);
        chk("R7 data hi", {24'h0, d}, (n * 613 >> 8) & 'hFF);
        rd(BASE + 'h0F, d);
        chk("R7 data lo", {24'h0, d}, (n * 613) & 'hFF);
      end
    end

    // R8 writes to read-only bytes ignored
    wr(BASE + 'h0D, 8'h55); wr(BASE + 'h0E, 8'h66); wr(BASE + 'h0F, 8'h77);
    rd(BASE + 'h0D, d); chk("R8 count ro", {24'h0, d}, 300 % 256);
    rd(BASE + 'h0E, d); chk("R8 data hi ro", {24'h0, d}, (300 * 613 >> 8) & 'hFF);
    rd(BASE + 'h0F, d); chk("R8 data lo ro", {24'h0, d}, (300 * 613) & 'hFF);

    // R5 soft reset beats a simultaneous read-back strobe
    rb_valid = 1; rb_data = 16'hABCD;
    wr(32'h0, 8'hFF); rb_valid = 0;
    rd(BASE + 'h0D, d); chk("R5 count cleared", {24'h0, d}, 0);
    rd(BASE + 'h0E, d); chk("R5 data cleared", {24'h0, d}, 0);

    // R8 unmapped addresses
    for (int o = 1; o <= 16; o++) wr(BASE + o, 8'hC3);
    begin
      logic [31:0] um [8] = '{BASE, BASE + 'h11, BASE + 'h1F, BASE + 'h101,
                              32'h2000_0001, 32'h0000_0001, 32'h1000_0021, 32'hFFFF_FC18};
      foreach (um[k]) begin
        rd(um[k], d);
        chk("R8 unmapped", {24'h0, d}, 0);
      end
    end

    // R9 read latency and hold
    host_addr = BASE + 1; host_rd = 1;
    chk("R9 before edge", {24'h0, host_rdata}, 0);
    @(negedge clk); host_rd = 0;
    chk("R9 loaded", {24'h0, host_rdata}, 32'hC3);
    host_addr = BASE + 'h11;
    repeat (3) @(negedge clk);
    chk("R9 held", {24'h0, host_rdata}, 32'hC3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule